// File: doc/BRIEF.md
# Bus Slave Address Function Decoder

This block decides whether a bus cycle is meant for this slave. Each request carries an address, a 6-bit address modifier (AM) and a data-width code. The block checks the request against a set of programmable decode functions. Each function has a base value, a mask, an expected AM and an enable bit. The block also checks for the configuration-space cycle, which is addressed by the board's slot number. The result states whether the cycle is claimed, which function claimed it or whether configuration space was selected, and the local address that the rest of the slave should use.

For a function hit, every bit that took part in the decode is cleared, so only the offset inside that function's window is left. For a configuration access, the slot field and all bits above it are cleared. The decode is combinational over the accepted request and the decode settings present in that cycle. The result is captured in one output register stage.

Requests enter through a valid/ready pair and results leave through a second valid/ready pair. A result is presented for every accepted request, in order. The result holds still while the consumer stalls. While a result is stalled, no new request is taken. The decode settings are plain level inputs and are sampled in the cycle a request is accepted.

Top module: `addr_func_decoder`

## Requirements
- R1: A request claims function i when the global enable is 1, the function's enable bit is 1, the request AM equals the function's AM, and (address AND mask) equals (base AND mask). The result then has hit=1, cfg=0, function index i, and one-hot bit i set.
- R2: For a function hit, the local address equals the request address with every bit set in that function's mask forced to zero.
- R3: When several functions match, the lowest-numbered one wins. Exactly one one-hot bit is set, and it is the bit at the reported index.
- R4: A function whose enable bit is 0 never matches. No function matches while the global enable is 0.
- R5: A configuration access is selected when all of these hold: the AM is 0x2F, the slot number is nonzero, address bits [23:19] equal the slot number, and the lane rule of R7 holds. Address bits above 23 are ignored. The result then has hit=1 and cfg=1.
- R6: For a configuration access, the local address is address bits [18:0] zero-extended, and the function index and one-hot vector are zero.
- R7: Width codes and lane rules for configuration accesses: code 0 is a single byte and requires address bits [1:0]=3; code 1 is two bytes and requires [1:0]=2; code 2 is four bytes and requires [1:0]=0. Code 3, or a code whose rule fails, selects no configuration access.
- R8: A configuration access takes priority over any function that also matches, and it is not gated by the global enable.
- R9: With slot number 0, no configuration access is ever selected.
- R10: A request that is not claimed gives hit=0, cfg=0, index 0, one-hot 0 and local address 0.
- R11: A request accepted on an edge (req_valid and req_ready both high) has its result valid from that edge on. The result holds unchanged while rsp_ready is low. req_ready equals (not rsp_valid) or rsp_ready.
- R12: During and after reset, rsp_valid is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_en | input | 1 | Global enable for the decode functions |
| slot_id | input | 5 | Slot number of the board (0 means not addressed by slot) |
| fn_base | input | NF*AW | Base value per function, function i at bits [i*AW +: AW] |
| fn_mask | input | NF*AW | Compare mask per function |
| fn_am | input | NF*6 | Expected AM per function |
| fn_en | input | NF | Enable bit per function |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | AW | Bus address |
| req_am | input | 6 | Address modifier |
| req_width | input | 2 | Width code (0 one byte, 1 two bytes, 2 four bytes, 3 reserved) |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | Cycle claimed (function or configuration) |
| rsp_cfg | output | 1 | Configuration space selected |
| rsp_fn_idx | output | IW | Index of the winning function |
| rsp_fn_onehot | output | NF | One-hot form of the winning function |
| rsp_local_addr | output | AW | Address with the decode bits cleared |

## Verification
Every result is due on the first clock edge after the edge that accepts its request. It stays on the outputs for as long as rsp_ready is low. The driver therefore samples req_ready a short time after the falling edge, before the accepting edge. The monitor compares a result only when it sees rsp_valid and rsp_ready together after a falling edge, and this is the pair that the next rising edge consumes. The consumer's ready follows an irregular pattern, so results are compared both right away and after stalls. A directed stall test reads the outputs at fixed falling edges after acceptance, to confirm the one-edge delay and the hold.

// File: rtl/afd_pkg.sv
package afd_pkg;
  localparam int AMW = 6;
  localparam int SLOTW = 5;
  localparam int CFG_OFS_W = 19;
  localparam int CFG_TOP = CFG_OFS_W + SLOTW;          // bits compared for config space
  localparam logic [AMW-1:0] CFG_AM = 6'h2F;

  typedef enum logic [1:0] {
    WID_BYTE = 2'd0,
    WID_HALF = 2'd1,
    WID_WORD = 2'd2,
    WID_RSV  = 2'd3
  } wid_e;
endpackage

// File: rtl/afd_fn_cmp.sv
module afd_fn_cmp
  import afd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]  addr,
  input  logic [AMW-1:0] am,
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  mask,
  input  logic [AMW-1:0] exp_am,
  input  logic           fn_on,
  input  logic           all_on,
  output logic           match
);
  logic addr_eq;
  logic am_eq;

  assign addr_eq = (((addr ^ base) & mask) == '0);
  assign am_eq   = (am == exp_am);
  assign match   = all_on & fn_on & am_eq & addr_eq;
endmodule

// File: rtl/afd_prio.sv
module afd_prio #(
  parameter int NF = 8,
  localparam int IW = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic [NF-1:0] req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [NF-1:0] onehot
);
  always_comb begin
    any    = 1'b0;
    idx    = '0;
    onehot = '0;
    for (int i = NF - 1; i >= 0; i--) begin
      if (req[i]) begin
        any    = 1'b1;
        idx    = IW'(i);
        onehot = NF'(1) << i;
      end
    end
  end
endmodule

// File: rtl/afd_cfg_match.sv
module afd_cfg_match
  import afd_pkg::*;
(
  input  logic [CFG_TOP-1:0]   addr,
  input  logic [AMW-1:0]       am,
  input  logic [1:0]           width,
  input  logic [SLOTW-1:0]     slot,
  output logic                 sel,
  output logic [CFG_OFS_W-1:0] ofs
);
  logic lane_ok;
  logic slot_eq;

  always_comb begin
    case (wid_e'(width))
      WID_BYTE: lane_ok = (addr[1:0] == 2'd3);
      WID_HALF: lane_ok = (addr[1:0] == 2'd2);
      WID_WORD: lane_ok = (addr[1:0] == 2'd0);
      default:  lane_ok = 1'b0;
    endcase
  end

  assign slot_eq = (slot != '0) && (addr[CFG_TOP-1:CFG_OFS_W] == slot);
  assign sel     = (am == CFG_AM) && slot_eq && lane_ok;
  assign ofs     = addr[CFG_OFS_W-1:0];
endmodule

// File: rtl/afd_rsp_reg.sv
module afd_rsp_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/addr_func_decoder.sv
module addr_func_decoder
  import afd_pkg::*;
#(
  parameter int NF = 8,
  parameter int AW = 32,
  localparam int IW = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dec_en,
  input  logic [SLOTW-1:0]   slot_id,
  input  logic [NF*AW-1:0]   fn_base,
  input  logic [NF*AW-1:0]   fn_mask,
  input  logic [NF*AMW-1:0]  fn_am,
  input  logic [NF-1:0]      fn_en,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [AW-1:0]      req_addr,
  input  logic [AMW-1:0]     req_am,
  input  logic [1:0]         req_width,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_hit,
  output logic               rsp_cfg,
  output logic [IW-1:0]      rsp_fn_idx,
  output logic [NF-1:0]      rsp_fn_onehot,
  output logic [AW-1:0]      rsp_local_addr
);
  localparam int RW = 2 + IW + NF + AW;

  logic [NF-1:0]        fn_hit;
  logic [AW-1:0]        mask_a [NF];
  logic                 any_fn;
  logic [IW-1:0]        win_idx;
  logic [NF-1:0]        win_oh;
  logic                 cfg_sel;
  logic [CFG_OFS_W-1:0] cfg_ofs;
  logic [AW-1:0]        fn_local;
  logic [RW-1:0]        nxt;
  logic [RW-1:0]        cur;

  for (genvar g = 0; g < NF; g++) begin : g_fn
    assign mask_a[g] = fn_mask[g*AW +: AW];
    afd_fn_cmp #(.AW(AW)) u_cmp (
      .addr   (req_addr),
      .am     (req_am),
      .base   (fn_base[g*AW +: AW]),
      .mask   (fn_mask[g*AW +: AW]),
      .exp_am (fn_am[g*AMW +: AMW]),
      .fn_on  (fn_en[g]),
      .all_on (dec_en),
      .match  (fn_hit[g])
    );
  end

  afd_prio #(.NF(NF)) u_prio (
    .req    (fn_hit),
    .any    (any_fn),
    .idx    (win_idx),
    .onehot (win_oh)
  );

  afd_cfg_match u_cfg (
    .addr  (req_addr[CFG_TOP-1:0]),
    .am    (req_am),
    .width (req_width),
    .slot  (slot_id),
    .sel   (cfg_sel),
    .ofs   (cfg_ofs)
  );

  assign fn_local = req_addr & ~mask_a[win_idx];

  always_comb begin
    if (cfg_sel)
      nxt = {1'b1, 1'b1, {IW{1'b0}}, {NF{1'b0}}, AW'(cfg_ofs)};
    else if (any_fn)
      nxt = {1'b1, 1'b0, win_idx, win_oh, fn_local};
    else
      nxt = '0;
  end

  afd_rsp_reg #(.W(RW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (nxt),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (cur)
  );

  assign {rsp_hit, rsp_cfg, rsp_fn_idx, rsp_fn_onehot, rsp_local_addr} = cur;
endmodule

// File: rtl/afd_chk.sv
module afd_chk #(
  parameter int NF = 8,
  parameter int AW = 32,
  localparam int IW = (NF > 1) ? $clog2(NF) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic          rsp_hit,
  input logic          rsp_cfg,
  input logic [IW-1:0] rsp_fn_idx,
  input logic [NF-1:0] rsp_fn_onehot,
  input logic [AW-1:0] rsp_local_addr
);
  // R11
  accept_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid &&
      $stable({rsp_hit, rsp_cfg, rsp_fn_idx, rsp_fn_onehot, rsp_local_addr}));

  // R11
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  // R3
  one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit && !rsp_cfg |->
      ($countones(rsp_fn_onehot) == 1) && rsp_fn_onehot[rsp_fn_idx]);

  // R6
  cfg_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_cfg |-> rsp_hit && (rsp_fn_onehot == '0) &&
      (rsp_fn_idx == '0) && ((rsp_local_addr >> 19) == '0));

  // R10
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> !rsp_cfg && (rsp_fn_onehot == '0) &&
      (rsp_fn_idx == '0) && (rsp_local_addr == '0));
endmodule

bind addr_func_decoder afd_chk #(.NF(NF), .AW(AW)) u_afd_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_hit        (rsp_hit),
  .rsp_cfg        (rsp_cfg),
  .rsp_fn_idx     (rsp_fn_idx),
  .rsp_fn_onehot  (rsp_fn_onehot),
  .rsp_local_addr (rsp_local_addr)
);

// File: tb/addr_func_decoder_test.sv
module addr_func_decoder_test;
  localparam int CLK_NS = 10;
  localparam int NF = 8;
  localparam int AW = 32;
  localparam int IW = 3;
  localparam int EW = 2 + IW + NF + AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_en = 1'b1;
  logic [4:0] slot_id = 5'd0;
  logic [NF*AW-1:0] fn_base = '0;
  logic [NF*AW-1:0] fn_mask = '0;
  logic [NF*6-1:0]  fn_am = '0;
  logic [NF-1:0]    fn_en = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [5:0] req_am = '0;
  logic [1:0] req_width = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b0;
  logic rsp_hit, rsp_cfg;
  logic [IW-1:0] rsp_fn_idx;
  logic [NF-1:0] rsp_fn_onehot;
  logic [AW-1:0] rsp_local_addr;

  int checks = 0;
  int fails = 0;
  bit stall = 1'b0;
  bit done = 1'b0;
  logic [EW-1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_NS/2) clk = ~clk;

  addr_func_decoder #(.NF(NF), .AW(AW)) uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [EW-1:0] act, input logic [EW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_fn(input int i, input logic [AW-1:0] b, input logic [AW-1:0] m,
                        input logic [5:0] a, input bit e);
    fn_base[i*AW +: AW] = b;
    fn_mask[i*AW +: AW] = m;
    fn_am[i*6 +: 6] = a;
    fn_en[i] = e;
  endtask

  // Expected result, built from the requirement text
  function automatic logic [EW-1:0] model(input logic [AW-1:0] a, input logic [5:0] am, input logic [1:0] w);
    bit lane;
    lane = (w == 2'd0 && a[1:0] == 2'd3) || (w == 2'd1 && a[1:0] == 2'd2) ||
           (w == 2'd2 && a[1:0] == 2'd0);
    if (am == 6'h2F && slot_id != 0 && a[23:19] == slot_id && lane)
      return {1'b1, 1'b1, 3'd0, 8'd0, {13'd0, a[18:0]}};
    if (dec_en)
      for (int i = 0; i < NF; i++) begin
        logic [AW-1:0] m;
        m = fn_mask[i*AW +: AW];
        if (fn_en[i] && fn_am[i*6 +: 6] == am && (a & m) == (fn_base[i*AW +: AW] & m))
          return {1'b1, 1'b0, IW'(i), NF'(1) << i, a & ~m};
      end
    return '0;
  endfunction

  // Driver: called at a falling edge, returns at a falling edge
  task automatic send(input logic [AW-1:0] a, input logic [5:0] am, input logic [1:0] w, input string tag);
    exp_q.push_back(model(a, am, w));
    tag_q.push_back(tag);
    req_addr = a; req_am = am; req_width = w; req_valid = 1'b1;
    forever begin
      #2;
      if (req_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor / scoreboard
  initial begin
    int cyc = 0;
    logic [7:0] pat = 8'b1101_0111;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        rsp_ready = stall ? 1'b0 : pat[cyc % 8];
        cyc++;
        #1;
        if (rsp_valid && rsp_ready) begin
          logic [EW-1:0] act, e;
          string t;
          act = {rsp_hit, rsp_cfg, rsp_fn_idx, rsp_fn_onehot, rsp_local_addr};
          if (exp_q.size() == 0) chk(1'b0, "R11 unexpected result", act, '0);
          else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(act == e, t, act, e);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R12 reset state",
        EW'({rsp_valid, req_ready}), EW'(2'b01));
    rst_n = 1'b1;
    set_fn(0, 32'h0100_0000, 32'hFF00_0000, 6'h09, 1'b1);
    set_fn(1, 32'h0020_0000, 32'hFFF0_0000, 6'h39, 1'b1);
    set_fn(2, 32'h0100_0000, 32'hFFF0_0000, 6'h09, 1'b1);
    set_fn(3, 32'h3000_0000, 32'hF000_0000, 6'h0D, 1'b0);
    slot_id = 5'd5;
    @(negedge clk);

    send(32'h0112_3456, 6'h09, 2'd2, "R1 R2 fn0 hit");
    send(32'h0023_4568, 6'h39, 2'd2, "R1 R2 fn1 hit");
    send(32'h0112_3456, 6'h39, 2'd2, "R10 AM mismatch miss");
    send(32'h0105_0000, 6'h09, 2'd2, "R3 overlap lowest wins");
    send(32'h3000_0010, 6'h0D, 2'd2, "R4 disabled fn miss");
    send(32'h0028_7FF3, 6'h2F, 2'd0, "R5 R7 cfg byte lane");
    send(32'hAB28_1002, 6'h2F, 2'd1, "R5 R6 cfg half upper bits ignored");
    send(32'h0028_0040, 6'h2F, 2'd2, "R7 cfg word");
    send(32'h0028_0040, 6'h2F, 2'd0, "R7 byte wrong lane miss");
    send(32'h0028_0043, 6'h2F, 2'd3, "R7 reserved width miss");
    send(32'h0030_0003, 6'h2F, 2'd0, "R5 other slot miss");
    drain();

    set_fn(0, 32'h0100_0000, 32'hFF00_0000, 6'h09, 1'b0);
    @(negedge clk);
    send(32'h0105_0000, 6'h09, 2'd2, "R3 fn2 wins when fn0 off");
    drain();

    dec_en = 1'b0;
    @(negedge clk);
    send(32'h0105_0000, 6'h09, 2'd2, "R4 global disable miss");
    send(32'h0028_0002, 6'h2F, 2'd1, "R8 cfg ignores global enable");
    drain();

    dec_en = 1'b1;
    set_fn(4, 32'h0000_0000, 32'h0000_0000, 6'h2F, 1'b1);
    @(negedge clk);
    send(32'h0028_0003, 6'h2F, 2'd0, "R8 cfg beats matching fn");
    send(32'h0030_0003, 6'h2F, 2'd0, "R8 fn4 takes non-slot cycle");
    drain();

    set_fn(4, 32'h0000_0000, 32'h0000_0000, 6'h2F, 1'b0);
    slot_id = 5'd0;
    @(negedge clk);
    send(32'h0000_0003, 6'h2F, 2'd0, "R9 slot zero no cfg");
    drain();

    set_fn(0, 32'h0100_0000, 32'hFF00_0000, 6'h09, 1'b1);
    stall = 1'b1;
    @(negedge clk);
    @(negedge clk);
    send(32'h0112_3456, 6'h09, 2'd2, "R11 stalled result");
    #3;
    chk(rsp_valid == 1'b1 && req_ready == 1'b0, "R11 valid one edge after accept",
        EW'({rsp_valid, req_ready}), EW'(2'b10));
    repeat (3) @(negedge clk);
    #3;
    chk(rsp_valid && rsp_hit && rsp_local_addr == 32'h0012_3456, "R11 R2 held during stall",
        EW'(rsp_local_addr), EW'(32'h0012_3456));
    stall = 1'b0;
    drain();
    chk(exp_q.size() == 0, "R11 all results delivered", EW'(exp_q.size()), '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule